// File: doc/BRIEF.md
# PCI Target Latency Watchdog

This block sits next to the local-side interface of a PCI target and enforces the target latency limits. While the target has claimed a transaction, the block counts clock cycles. The first budget runs from the moment the local transaction strobe goes active until the first completed data transfer. Each later budget runs from one completed transfer to the next. The first budget is shorter than the bus allows for a first data phase. The difference leaves room for the cycles the target core uses between the address phase and the local strobe.

A local client can run out of its budget. When that happens, the block raises a registered disconnect request so that the target can end the transaction with a retry or disconnect termination. The request stays up until the local strobe is released. If no transfer completes within a grace window after the request rises, a one-cycle violation pulse is emitted for system-level error logging. All budgets are parameters. The defaults are 12 cycles for the first transfer, 8 cycles between transfers and 4 cycles of grace.

Top module: `pci_tgt_latency_guard`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `disc_req` and `lat_viol` are 0 whatever the other inputs do.
- R2: Call the rising edge at which `txn_act` is first sampled high edge 0. If no transfer is sampled at edges 1 through FIRST_BUDGET, `disc_req` is 1 after edge FIRST_BUDGET. A transfer at edge FIRST_BUDGET or earlier keeps it at 0.
- R3: After a completed transfer at edge T, if no further transfer is sampled at edges T+1 through T+LATER_BUDGET, `disc_req` is 1 after edge T+LATER_BUDGET. Otherwise it stays at 0.
- R4: A transfer counts only when `xfer_ack` and `lcl_rdy` are both 1 in the same cycle. Either one alone does not reset a budget.
- R5: Every completed transfer restarts the later-phase budget. A stream of transfers spaced exactly LATER_BUDGET cycles apart never raises `disc_req`.
- R6: Once `disc_req` is 1, it stays 1 on every cycle while `txn_act` stays 1, including when transfers occur.
- R7: An edge that samples `txn_act` low clears `disc_req`, `lat_viol` and all counters. The next transaction is again timed with FIRST_BUDGET.
- R8: The disconnect request rises at edge H. If no transfer is sampled at edges H+1 through H+GRACE, `lat_viol` is 1 for exactly the one cycle after edge H+GRACE. A transfer inside that window suppresses the pulse. `lat_viol` is 1 only while `disc_req` is 1.
- R9: Transfers sampled while no transaction is active have no effect on either output.
- R10: If `txn_act` falls before a budget runs out, no request is raised, and the next transaction starts with a fresh count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txn_act | input | 1 | Local transaction strobe, high while the target holds a claimed transaction |
| lcl_rdy | input | 1 | Local client ready to take data |
| xfer_ack | input | 1 | Target data strobe toward the local client |
| disc_req | output | 1 | Registered request to terminate the transaction |
| lat_viol | output | 1 | Registered one-cycle pulse when the grace window after a request expires |

## Verification
The bench aims at the budget boundaries. A transfer landing on the last allowed cycle must not raise a request, and an off-by-one counter would disconnect one cycle early or late. Half transfers are tested: a design that accepted either strobe alone would never time out. A transaction that reaches the later phase is dropped and then restarted. A design that kept its phase or count across transactions would disconnect after 8 cycles instead of 12. The grace window is checked both ways, with a transfer inside it and without one, to catch a missing, misplaced or repeated violation pulse.

// File: rtl/lat_wd_pkg.sv
package lat_wd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FIRST = 2'd1,
    PH_LATER = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lat_wd_cycle_ctr.sv
module lat_wd_cycle_ctr #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         at_limit
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= W'(1);
    end else if (inc && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign at_limit = (cnt_q == limit);

  // R5: the controller never asks for a step past the window limit
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && !clr) |-> (cnt_q < limit));

endmodule

// File: rtl/lat_wd_phase_ctl.sv
module lat_wd_phase_ctl
  import lat_wd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   txn,
  input  logic   xfer,
  input  logic   win_hit,
  input  logic   grace_hit,
  output phase_e phase,
  output logic   win_clr,
  output logic   win_load,
  output logic   win_inc,
  output logic   g_clr,
  output logic   g_load,
  output logic   g_inc,
  output logic   disc_q,
  output logic   viol_q
);

  phase_e phase_q, phase_n;
  logic   disc_n, viol_n, stop_q, stop_n;

  always_comb begin
    phase_n  = phase_q;
    disc_n   = disc_q;
    viol_n   = 1'b0;
    stop_n   = stop_q;
    win_clr  = 1'b0;
    win_load = 1'b0;
    win_inc  = 1'b0;
    g_clr    = 1'b0;
    g_load   = 1'b0;
    g_inc    = 1'b0;
    if (!txn) begin
      phase_n = PH_IDLE;
      disc_n  = 1'b0;
      stop_n  = 1'b0;
      win_clr = 1'b1;
      g_clr   = 1'b1;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_n  = PH_FIRST;
          win_load = 1'b1;
        end
        PH_FIRST, PH_LATER: begin
          if (xfer) begin
            phase_n  = PH_LATER;
            win_load = 1'b1;
          end else if (win_hit) begin
            phase_n = PH_HOLD;
            disc_n  = 1'b1;
            stop_n  = 1'b0;
            win_clr = 1'b1;
            g_load  = 1'b1;
          end else begin
            win_inc = 1'b1;
          end
        end
        PH_HOLD: begin
          if (xfer) begin
            stop_n = 1'b1;
          end else if (!stop_q) begin
            if (grace_hit) begin
              viol_n = 1'b1;
              stop_n = 1'b1;
            end else begin
              g_inc = 1'b1;
            end
          end
        end
        default: phase_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      disc_q  <= 1'b0;
      viol_q  <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      disc_q  <= disc_n;
      viol_q  <= viol_n;
      stop_q  <= stop_n;
    end
  end

  assign phase = phase_q;

  p_disc_held_r6: assert property (@(posedge clk) disable iff (rst)
    (disc_q && txn) |=> disc_q);

  p_drop_clears_r7: assert property (@(posedge clk) disable iff (rst)
    !txn |=> (!disc_q && !viol_q));

  p_viol_single_r8: assert property (@(posedge clk) disable iff (rst)
    viol_q |=> !viol_q);

  p_viol_under_disc_r8: assert property (@(posedge clk) disable iff (rst)
    viol_q |-> disc_q);

  // R2 / R3: a request rises only when the active window counter reached its limit
  p_disc_after_hit_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(disc_q) |-> $past(win_hit));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE) |-> !disc_q);

endmodule

// File: rtl/pci_tgt_latency_guard.sv
module pci_tgt_latency_guard
  import lat_wd_pkg::*;
#(
  parameter int unsigned FIRST_BUDGET = 12,
  parameter int unsigned LATER_BUDGET = 8,
  parameter int unsigned GRACE        = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic txn_act,
  input  logic lcl_rdy,
  input  logic xfer_ack,
  output logic disc_req,
  output logic lat_viol
);

  localparam int unsigned MAXV = max3(FIRST_BUDGET, LATER_BUDGET, GRACE);
  localparam int unsigned CW   = $clog2(MAXV + 1);

  phase_e        phase;
  logic          xfer;
  logic [CW-1:0] win_limit;
  logic          win_clr, win_load, win_inc, win_hit;
  logic          g_clr, g_load, g_inc, grace_hit;

  assign xfer      = xfer_ack && lcl_rdy;
  assign win_limit = (phase == PH_FIRST) ? CW'(FIRST_BUDGET) : CW'(LATER_BUDGET);

  lat_wd_phase_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .txn      (txn_act),
    .xfer     (xfer),
    .win_hit  (win_hit),
    .grace_hit(grace_hit),
    .phase    (phase),
    .win_clr  (win_clr),
    .win_load (win_load),
    .win_inc  (win_inc),
    .g_clr    (g_clr),
    .g_load   (g_load),
    .g_inc    (g_inc),
    .disc_q   (disc_req),
    .viol_q   (lat_viol)
  );

  lat_wd_cycle_ctr #(.W(CW)) u_win (
    .clk     (clk),
    .rst     (rst),
    .clr     (win_clr),
    .load    (win_load),
    .inc     (win_inc),
    .limit   (win_limit),
    .at_limit(win_hit)
  );

  lat_wd_cycle_ctr #(.W(CW)) u_grace (
    .clk     (clk),
    .rst     (rst),
    .clr     (g_clr),
    .load    (g_load),
    .inc     (g_inc),
    .limit   (CW'(GRACE)),
    .at_limit(grace_hit)
  );

  initial begin
    a_budgets_nonzero_r2: assert (FIRST_BUDGET >= 1 && LATER_BUDGET >= 1 && GRACE >= 1);
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!disc_req && !lat_viol));

endmodule

// File: tb/test_pci_tgt_latency_guard.sv
module test_pci_tgt_latency_guard;

  localparam int FB = 12;
  localparam int LB = 8;
  localparam int G  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txn_act = 1'b0, lcl_rdy = 1'b0, xfer_ack = 1'b0;
  logic disc_req, lat_viol;

  always #2.5 clk = ~clk;

  pci_tgt_latency_guard #(.FIRST_BUDGET(FB), .LATER_BUDGET(LB), .GRACE(G)) i_pci_tgt_latency_guard (
    .clk(clk), .rst(rst), .txn_act(txn_act), .lcl_rdy(lcl_rdy), .xfer_ack(xfer_ack),
    .disc_req(disc_req), .lat_viol(lat_viol)
  );

  typedef struct {
    bit    ed;
    bit    ev;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input bit ad, input bit av, input bit ed, input bit ev, input string tag);
    checks++;
    if (ad !== ed || av !== ev) begin
      fails++;
      $display("FAIL %s: disc_req/lat_viol = %0b/%0b, expected %0b/%0b at %0t",
               tag, ad, av, ed, ev, $time);
    end
  endtask

  // monitor: compares outputs after each edge against the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        check(disc_req, lat_viol, it.ed, it.ev, it.tag);
      end
    end
  end

  task automatic cyc(input bit t, input bit a, input bit r, input bit ed, input bit ev,
                     input string tag);
    txn_act  = t;
    xfer_ack = a;
    lcl_rdy  = r;
    q.push_back('{ed, ev, tag});
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset holds outputs low even with an active strobe and transfers
    txn_act = 1'b1; xfer_ack = 1'b1; lcl_rdy = 1'b1;
    repeat (3) @(negedge clk);
    check(disc_req, lat_viol, 1'b0, 1'b0, "R1");
    rst = 1'b0;
    txn_act = 1'b0; xfer_ack = 1'b0; lcl_rdy = 1'b0;
    @(negedge clk);
    check(disc_req, lat_viol, 1'b0, 1'b0, "R1");

    // R2 timeout, R6 hold, R8 grace pulse
    for (int n = 0; n <= FB + G + 2; n++)
      cyc(1, 0, 0, n >= FB, n == FB + G, (n < FB) ? "R2" : (n == FB + G) ? "R8" : "R6");
    cyc(0, 0, 0, 0, 0, "R7");

    // R9: transfers while idle have no effect
    for (int n = 0; n < 3; n++) cyc(0, 1, 1, 0, 0, "R9");

    // R2 boundary transfer, R3 later timeout, R8 suppressed by transfer in grace
    for (int n = 0; n <= FB; n++) cyc(1, n == FB, n == FB, 0, 0, "R2");
    for (int m = 1; m <= LB; m++) cyc(1, 0, 0, m == LB, 0, "R3");
    cyc(1, 1, 1, 1, 0, "R6");
    for (int k = 0; k <= G + 2; k++) cyc(1, 0, 0, 1, 0, "R8");
    cyc(0, 0, 0, 0, 0, "R7");

    // R4: half transfers never count
    for (int n = 0; n <= FB; n++) cyc(1, (n % 2) == 0, (n % 2) == 1, n >= FB, 0, "R4");
    cyc(0, 0, 0, 0, 0, "R7");

    // R5: transfers at the later-budget limit keep the request low
    cyc(1, 0, 0, 0, 0, "R5");
    cyc(1, 1, 1, 0, 0, "R5");
    for (int rep = 0; rep < 5; rep++)
      for (int m = 1; m <= LB; m++) cyc(1, m == LB, m == LB, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, "R7");

    // R10: strobe dropped before the limit, then a fresh count
    for (int n = 0; n < FB; n++) cyc(1, 0, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, "R10");
    for (int n = 0; n <= FB; n++) cyc(1, 0, 0, n >= FB, 0, "R10");
    cyc(0, 0, 0, 0, 0, "R7");

    // R7: a transaction that reached the later phase, then a new one uses the first budget
    cyc(1, 0, 0, 0, 0, "R7");
    cyc(1, 1, 1, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, "R7");
    for (int n = 0; n <= FB; n++) cyc(1, 0, 0, n >= FB, 0, "R7");
    cyc(0, 0, 0, 0, 0, "R7");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule